// File: doc/BRIEF.md
# Edge-Triggered BCD Down-Counter Bank

A bank of preset down counters that a scan-based control engine services one counter per request. For every scan the engine presents a counter index, a count condition, a reset condition and a four-digit BCD preset. The addressed counter compares both conditions with the values it saw on its own previous scan. A false-to-true change of the count condition lowers its present value by one. A false-to-true change of the reset condition loads the preset.

Reset has priority. While the reset condition is held, the counter does not count and its present value does not move. The counter reports completion once a count step has left it at zero. That completion flag stays set until the counter is reset again. The present value and the completion flag of the addressed counter come back, registered, one cycle after the request.

Present values and completion flags are kept in a small memory that the block-level reset does not clear, so they survive that reset. The per-counter edge history lives in flops, and the block-level reset does clear it.

Top module: `edge_down_counter_bank`

## Requirements
- R1: A scan with the count condition true, where that counter's previous scan had it false, and reset false, lowers the present value by one in BCD, borrowing across digits (1000 becomes 0999).
- R2: A scan whose count condition is steady (true after true, false after false) or falls leaves the present value unchanged.
- R3: A count step that leaves the present value at 0000 sets the completion flag. The flag then stays set across later scans until the reset condition is true.
- R4: A count edge at 0000 leaves the present value at 0000; it never wraps.
- R5: A scan whose reset condition is true after being false on that counter's previous scan loads the preset as the present value and clears the completion flag.
- R6: On scans where the reset condition stays true, the present value is unchanged, preset changes and count edges have no effect, and the flag reads low. After release, the first false-to-true count change lowers the loaded value by one. A count condition held true across the release does not count.
- R7: A scan changes only the addressed counter; every other counter keeps its present value and flag.
- R8: While the block reset is high, and on the first edge after it, out_valid, present-value output and flag output read zero. Stored present values and flags are kept. The edge history of every counter is cleared, so the next count or reset condition seen true counts as a rising change.
- R9: The result of a scan appears on the outputs, with out_valid high, exactly one cycle after the request. out_valid is low in cycles that follow no request.
- R10: Edge detection compares against the counter's own previous scan, even when scans of other counters come in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high block reset |
| scan_valid | input | 1 | A counter is being serviced this cycle |
| scan_idx | input | IDX_W | Index of the serviced counter |
| cnt_cond | input | 1 | Count condition for this scan |
| rst_cond | input | 1 | Reset condition for this scan |
| set_bcd | input | VAL_W | Preset, DIGITS BCD digits |
| out_valid | output | 1 | Outputs carry the result of the previous cycle's scan |
| pv_bcd | output | VAL_W | Present value after the scan, BCD |
| done_flag | output | 1 | Completion flag after the scan |

## Verification
Several properties are checked on every cycle: the one-cycle result timing and idle behaviour, that a raised completion flag always comes with a zero present value, that a scan holding reset always returns a low flag, and the quiet outputs after block reset. Other behaviours depend on each counter's own history, and only the bench's scenarios and reference model can show them. These include the BCD borrow, saturation at zero, loading on a reset rise but not while reset is held, per-counter edge memory across interleaved scans, and retention of values through block reset.

// File: rtl/edc_pkg.sv
package edc_pkg;
  typedef logic [3:0] bcd_digit_t;
  localparam bcd_digit_t BCD_NINE = 4'd9;
  localparam bcd_digit_t BCD_ZERO = 4'd0;
endpackage

// File: rtl/bcd_down_sat.sv
module bcd_down_sat #(
  parameter int DIGITS = 4,
  localparam int W = 4 * DIGITS
) (
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         was_zero
);
  import edc_pkg::*;

  logic [DIGITS:0] brw;
  logic [W-1:0]    dec;

  assign brw[0] = 1'b1;

  for (genvar g = 0; g < DIGITS; g++) begin : g_dig
    bcd_digit_t d;
    assign d = din[4*g +: 4];
    assign dec[4*g +: 4] = brw[g] ? ((d == BCD_ZERO) ? BCD_NINE : d - 4'd1) : d;
    assign brw[g+1] = brw[g] & (d == BCD_ZERO);
  end

  // a borrow out of the top digit means every digit was zero
  assign was_zero = brw[DIGITS];
  assign dout     = was_zero ? din : dec;
endmodule

// File: rtl/ctr_edge_track.sv
module ctr_edge_track #(
  parameter int NUM_CTR = 16,
  localparam int IDX_W = (NUM_CTR > 1) ? $clog2(NUM_CTR) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [IDX_W-1:0] idx,
  input  logic             cnt_now,
  input  logic             rst_now,
  output logic             cnt_prev,
  output logic             rst_prev
);
  logic [NUM_CTR-1:0] cnt_hist;
  logic [NUM_CTR-1:0] rst_hist;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_hist <= '0;
      rst_hist <= '0;
    end else if (we) begin
      cnt_hist[idx] <= cnt_now;
      rst_hist[idx] <= rst_now;
    end
  end

  assign cnt_prev = cnt_hist[idx];
  assign rst_prev = rst_hist[idx];
endmodule

// File: rtl/ctr_word_ram.sv
module ctr_word_ram #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 17,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    addr,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];
endmodule

// File: rtl/ctr_next_state.sv
module ctr_next_state #(
  parameter int DIGITS = 4,
  localparam int W = 4 * DIGITS
) (
  input  logic         cnt_now,
  input  logic         cnt_prev,
  input  logic         rst_now,
  input  logic         rst_prev,
  input  logic [W-1:0] preset,
  input  logic [W-1:0] cur_pv,
  input  logic         cur_done,
  output logic [W-1:0] nxt_pv,
  output logic         nxt_done
);
  logic [W-1:0] dec_pv;
  logic         unused_zero;

  bcd_down_sat #(.DIGITS(DIGITS)) u_dec (
    .din      (cur_pv),
    .dout     (dec_pv),
    .was_zero (unused_zero)
  );

  always_comb begin
    nxt_pv   = cur_pv;
    nxt_done = cur_done;
    if (rst_now) begin
      nxt_done = 1'b0;
      if (!rst_prev) nxt_pv = preset;
    end else if (cnt_now && !cnt_prev) begin
      nxt_pv = dec_pv;
      if (dec_pv == '0 || unused_zero) nxt_done = 1'b1;
    end
  end
endmodule

// File: rtl/edge_down_counter_bank.sv
module edge_down_counter_bank #(
  parameter int NUM_CTR = 16,
  parameter int DIGITS  = 4,
  localparam int IDX_W = (NUM_CTR > 1) ? $clog2(NUM_CTR) : 1,
  localparam int VAL_W = 4 * DIGITS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             scan_valid,
  input  logic [IDX_W-1:0] scan_idx,
  input  logic             cnt_cond,
  input  logic             rst_cond,
  input  logic [VAL_W-1:0] set_bcd,
  output logic             out_valid,
  output logic [VAL_W-1:0] pv_bcd,
  output logic             done_flag
);
  localparam int WORD_W = VAL_W + 1;

  logic              cnt_prev, rst_prev;
  logic [WORD_W-1:0] cur_word, nxt_word;
  logic [VAL_W-1:0]  nxt_pv;
  logic              nxt_done;
  logic              wr_en;

  assign wr_en = scan_valid && !rst;

  ctr_edge_track #(.NUM_CTR(NUM_CTR)) u_hist (
    .clk      (clk),
    .rst      (rst),
    .we       (wr_en),
    .idx      (scan_idx),
    .cnt_now  (cnt_cond),
    .rst_now  (rst_cond),
    .cnt_prev (cnt_prev),
    .rst_prev (rst_prev)
  );

  ctr_word_ram #(.DEPTH(NUM_CTR), .WIDTH(WORD_W)) u_ram (
    .clk   (clk),
    .we    (wr_en),
    .addr  (scan_idx),
    .wdata (nxt_word),
    .rdata (cur_word)
  );

  ctr_next_state #(.DIGITS(DIGITS)) u_nxt (
    .cnt_now  (cnt_cond),
    .cnt_prev (cnt_prev),
    .rst_now  (rst_cond),
    .rst_prev (rst_prev),
    .preset   (set_bcd),
    .cur_pv   (cur_word[VAL_W-1:0]),
    .cur_done (cur_word[VAL_W]),
    .nxt_pv   (nxt_pv),
    .nxt_done (nxt_done)
  );

  assign nxt_word = {nxt_done, nxt_pv};

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      pv_bcd    <= '0;
      done_flag <= 1'b0;
    end else begin
      out_valid <= scan_valid;
      if (scan_valid) begin
        pv_bcd    <= nxt_pv;
        done_flag <= nxt_done;
      end
    end
  end
endmodule

// File: rtl/edge_down_counter_bank_chk.sv
module edge_down_counter_bank_chk #(
  parameter int IDX_W = 4,
  parameter int VAL_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             scan_valid,
  input logic [IDX_W-1:0] scan_idx,
  input logic             cnt_cond,
  input logic             rst_cond,
  input logic [VAL_W-1:0] set_bcd,
  input logic             out_valid,
  input logic [VAL_W-1:0] pv_bcd,
  input logic             done_flag
);
  logic unused_in;
  assign unused_in = ^{scan_idx, cnt_cond, set_bcd};

  AST_RESULT_NEXT_CYCLE: assert property (@(posedge clk) disable iff (rst)
    scan_valid |=> out_valid); // R9
  AST_IDLE_NO_RESULT: assert property (@(posedge clk) disable iff (rst)
    !scan_valid |=> !out_valid); // R9
  AST_DONE_MEANS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (out_valid && done_flag) |-> (pv_bcd == '0)); // R3
  AST_RESET_HOLD_DONE_LOW: assert property (@(posedge clk) disable iff (rst)
    (scan_valid && rst_cond) |=> !done_flag); // R5
  AST_BLOCK_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!out_valid && pv_bcd == '0 && !done_flag)); // R8
endmodule

bind edge_down_counter_bank edge_down_counter_bank_chk #(
  .IDX_W(IDX_W), .VAL_W(VAL_W)
) u_chk (.*);

// File: tb/test_edge_down_counter_bank.sv
module test_edge_down_counter_bank;
  localparam int N  = 16;
  localparam int IW = 4;
  localparam int VW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scan_valid = 1'b0;
  logic [IW-1:0] scan_idx = '0;
  logic cnt_cond = 1'b0, rst_cond = 1'b0;
  logic [VW-1:0] set_bcd = '0;
  logic out_valid, done_flag;
  logic [VW-1:0] pv_bcd;

  int checks = 0, failures = 0;
  bit finished = 0;

  int mpv[N];
  bit mdone[N], mpc[N], mpr[N];

  always #4 clk = ~clk;

  edge_down_counter_bank #(.NUM_CTR(N), .DIGITS(4)) i_edge_down_counter_bank (
    .clk(clk), .rst(rst), .scan_valid(scan_valid), .scan_idx(scan_idx),
    .cnt_cond(cnt_cond), .rst_cond(rst_cond), .set_bcd(set_bcd),
    .out_valid(out_valid), .pv_bcd(pv_bcd), .done_flag(done_flag)
  );

  function automatic logic [15:0] to_bcd(input int v);
    logic [15:0] r = '0;
    int x = v;
    for (int i = 0; i < 4; i++) begin
      r[4*i +: 4] = 4'(x % 10);
      x = x / 10;
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic scan(input int idx, input bit c, input bit r, input int sv, input bit verify);
    string tag;
    @(negedge clk);
    scan_valid = 1'b1; scan_idx = IW'(idx); cnt_cond = c; rst_cond = r; set_bcd = to_bcd(sv);
    if (r) tag = mpr[idx] ? "R6" : "R5";
    else if (c && !mpc[idx]) tag = (mpv[idx] == 0) ? "R4" : "R1";
    else tag = "R2";
    if (r) begin
      mdone[idx] = 0;
      if (!mpr[idx]) mpv[idx] = sv;
    end else if (c && !mpc[idx]) begin
      if (mpv[idx] > 0) mpv[idx]--;
      if (mpv[idx] == 0) mdone[idx] = 1;
    end
    mpc[idx] = c; mpr[idx] = r;
    @(negedge clk);
    scan_valid = 1'b0;
    if (verify) begin
      chk(out_valid == 1'b1, "R9 result valid", int'(out_valid), 1);
      chk(pv_bcd == to_bcd(mpv[idx]), tag, int'(pv_bcd), int'(to_bcd(mpv[idx])));
      chk(done_flag == mdone[idx], "R3 flag", int'(done_flag), int'(mdone[idx]));
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    for (int i = 0; i < N; i++) begin mpc[i] = 0; mpr[i] = 0; mdone[i] = 0; mpv[i] = 0; end
    repeat (3) @(negedge clk);
    // R8 reset state
    chk(out_valid == 0 && pv_bcd == 0 && done_flag == 0, "R8 reset state", int'(pv_bcd), 0);
    rst = 1'b0;
    for (int i = 0; i < N; i++) scan(i, 0, 1, (i == 0) ? 3 : (i == 1) ? 1000 : 20 + i * 7, 1);
    // R9: no result in the cycle after an idle cycle
    @(negedge clk);
    chk(out_valid == 0, "R9 idle", int'(out_valid), 0);

    // R1 borrow across digits
    scan(1, 0, 0, 0, 1);
    scan(1, 1, 0, 0, 1);
    chk(pv_bcd == 16'h0999, "R1 borrow", int'(pv_bcd), 16'h0999);
    // R2 steady high, then falling
    scan(1, 1, 0, 0, 1);
    scan(1, 0, 0, 0, 1);
    chk(pv_bcd == 16'h0999, "R2 no count", int'(pv_bcd), 16'h0999);

    // R3/R4 on counter 0 (preset 3)
    for (int k = 0; k < 3; k++) begin scan(0, 0, 0, 0, 1); scan(0, 1, 0, 0, 1); end
    chk(pv_bcd == 0 && done_flag == 1, "R3 reached zero", int'(pv_bcd), 0);
    scan(0, 0, 0, 0, 1); scan(0, 1, 0, 0, 1);
    chk(pv_bcd == 0 && done_flag == 1, "R4 no wrap", int'(pv_bcd), 0);
    // R5 reload, R6 hold
    scan(0, 1, 1, 42, 1);
    chk(pv_bcd == 16'h0042 && done_flag == 0, "R5 load", int'(pv_bcd), 16'h0042);
    scan(0, 0, 1, 77, 1); scan(0, 1, 1, 88, 1);
    chk(pv_bcd == 16'h0042, "R6 held", int'(pv_bcd), 16'h0042);
    scan(0, 1, 0, 0, 1);
    chk(pv_bcd == 16'h0042, "R6 held count no edge", int'(pv_bcd), 16'h0042);
    scan(0, 0, 0, 0, 1); scan(0, 1, 0, 0, 1);
    chk(pv_bcd == 16'h0041, "R6 resume", int'(pv_bcd), 16'h0041);

    // R10 / R7 interleaving
    scan(2, 0, 0, 0, 1);
    scan(3, 1, 0, 0, 1);
    scan(2, 1, 0, 0, 1);
    chk(pv_bcd == to_bcd(33), "R10 edge across scans", int'(pv_bcd), int'(to_bcd(33)));
    scan(3, 0, 0, 0, 1);
    chk(pv_bcd == to_bcd(40), "R7 neighbour untouched", int'(pv_bcd), int'(to_bcd(40)));

    // R8 retention with history cleared
    scan(4, 1, 0, 0, 1);
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(out_valid == 0 && pv_bcd == 0, "R8 outputs cleared", int'(pv_bcd), 0);
    rst = 1'b0;
    for (int i = 0; i < N; i++) begin mpc[i] = 0; mpr[i] = 0; end
    scan(4, 1, 0, 0, 1);
    chk(pv_bcd == to_bcd(46), "R8 retained and edge re-armed", int'(pv_bcd), int'(to_bcd(46)));

    // random mix
    void'($urandom(32'd1234));
    for (int n = 0; n < 3000; n++) begin
      int idx = int'($urandom % N);
      bit c = 1'($urandom % 2);
      bit r = (($urandom % 10) == 0);
      int sv = int'($urandom % 40);
      scan(idx, c, r, sv, 1);
    end
    finish_run();
  end
endmodule